// File: doc/BRIEF.md
# Paired Prescaler and Clock-Select Tick Generator

This block turns a free-running input clock into one counting-enable pulse per PWM channel. Channels are grouped in pairs, and each pair shares an 8-bit prescaler that divides the input clock by its programmed value plus one. Behind the shared prescaler, every channel has its own power-of-two divider whose ratio comes from a 3-bit selector field. The four tick outputs are single-cycle strobes in the input clock domain, and downstream waveform counters use them as their count enables.

Configuration arrives as two static words. The prescale word holds one byte per channel pair. The clock-select word holds one 4-bit slot per channel, of which only the low 3 bits are decoded. Whenever a pair's prescale byte or the selector of either of its channels changes, that pair's prescaler and both of its dividers restart together. As a result, the first tick after a reconfiguration arrives exactly one full new period later.

Top module: `pwm_tick_gen`

## Requirements
- R1: While `rst_n` is low, all ticks are 0. After a release with both configuration words at zero, each channel's first tick appears after the second rising clock edge.
- R2: A prescale byte value P divides the input clock by P+1. With the bypass selector, the tick period is P+1 cycles.
- R3: Channels 0 and 1 use prescale bits [7:0], and channels 2 and 3 use prescale bits [15:8].
- R4: Channel c decodes its selector from clock-select bits [4c+2:4c]. Bits 3, 7, 11 and 15 are ignored, and changing them neither alters the rate nor restarts a channel.
- R5: Selector codes 0, 1, 2 and 3 divide the prescaled rate further by 2, 4, 8 and 16.
- R6: Selector code 4 adds no division. With prescale 0 and code 4, the tick is high on every cycle.
- R7: Selector codes 5, 6 and 7 behave exactly as code 4.
- R8: A change to a pair's prescale byte or to either selector of that pair restarts the pair. Ticks are 0 for the cycle after the change is sampled, and the first tick comes (P+1)·N cycles after that edge, where N is the selected divide ratio.
- R9: Whenever the total period exceeds one cycle, each tick lasts exactly one cycle.
- R10: Reconfiguring one pair does not disturb the tick schedule of the other pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, also the tick clock domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| prescale_cfg | input | 16 | One prescale byte per channel pair |
| clksel_cfg | input | 16 | One 4-bit slot per channel, low 3 bits decoded |
| tick | output | 4 | Single-cycle counting enable per channel |

## Verification
The bench targets the off-by-one points of the division chain: a design that divides by P instead of P+1, or that misses one stage of the power-of-two ratio, places its first tick at the wrong cycle index. The bench also drives codes 5 to 7 and reserved selector bits; a decoder that is one bit too wide or has a missing clamp would then change rate or restart a channel. Reconfiguring one pair while the other keeps counting catches a restart that leaks across pairs. A mid-period change catches a design that keeps a stale count and emits an early tick.

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int NCH        = 4,
  parameter int CH_PER_PRE = 2,
  parameter int PRE_W      = 8,
  parameter int SEL_W      = 3,
  parameter int SEL_STRIDE = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NCH/CH_PER_PRE*PRE_W-1:0] prescale_cfg,
  input  logic [NCH*SEL_STRIDE-1:0]     clksel_cfg,
  output logic [NCH-1:0]                tick
);
  localparam int NPRE  = NCH / CH_PER_PRE;
  localparam int DIV_W = 2 ** (SEL_W - 1);

  logic [NPRE-1:0] pre_hit;
  logic [NPRE-1:0] pair_restart;
  logic [NCH-1:0]  sel_chg;
  logic [NCH-1:0]  unused_rsv;

  for (genvar p = 0; p < NPRE; p++) begin : g_pair
    logic [PRE_W-1:0] pre_r;
    logic [PRE_W-1:0] cnt;
    wire  [PRE_W-1:0] byte_in = prescale_cfg[p*PRE_W +: PRE_W];

    assign pair_restart[p] = (byte_in != pre_r) | (|sel_chg[p*CH_PER_PRE +: CH_PER_PRE]);
    assign pre_hit[p]      = (cnt == pre_r);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pre_r <= '0;
        cnt   <= '0;
      end else begin
        pre_r <= byte_in;
        cnt   <= (pair_restart[p] || pre_hit[p]) ? '0 : cnt + 1'b1;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int P = c / CH_PER_PRE;
    logic [SEL_W-1:0] sel_r;
    logic [DIV_W-1:0] dcnt;
    logic [DIV_W-1:0] dlast;
    logic             t_r;
    wire  [SEL_W-1:0] sel_in = clksel_cfg[c*SEL_STRIDE +: SEL_W];

    assign unused_rsv[c] = ^clksel_cfg[c*SEL_STRIDE+SEL_W +: SEL_STRIDE-SEL_W];
    assign sel_chg[c]    = (sel_in != sel_r);
    assign dlast         = (int'(sel_r) < DIV_W) ? DIV_W'((2 << sel_r) - 1) : '0;
    assign tick[c]       = t_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_r <= '0;
        dcnt  <= '0;
        t_r   <= 1'b0;
      end else begin
        sel_r <= sel_in;
        if (pair_restart[P]) begin
          dcnt <= '0;
          t_r  <= 1'b0;
        end else begin
          t_r <= pre_hit[P] && (dcnt == dlast);
          if (pre_hit[P])
            dcnt <= (dcnt == dlast) ? '0 : dcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_tick_gen_chk.sv
module pwm_tick_gen_chk #(
  parameter int NCH        = 4,
  parameter int CH_PER_PRE = 2,
  parameter int PRE_W      = 8,
  parameter int SEL_W      = 3,
  parameter int SEL_STRIDE = 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NCH/CH_PER_PRE*PRE_W-1:0] prescale_cfg,
  input logic [NCH*SEL_STRIDE-1:0]       clksel_cfg,
  input logic [NCH-1:0]                  tick
);
  localparam int NPRE  = NCH / CH_PER_PRE;
  localparam int DIV_W = 2 ** (SEL_W - 1);

  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  for (genvar p = 0; p < NPRE; p++) begin : g_pair
    logic [CH_PER_PRE*SEL_W-1:0] fields;
    wire  [PRE_W-1:0]            pbyte = prescale_cfg[p*PRE_W +: PRE_W];
    always_comb
      for (int i = 0; i < CH_PER_PRE; i++)
        fields[i*SEL_W +: SEL_W] = clksel_cfg[(p*CH_PER_PRE+i)*SEL_STRIDE +: SEL_W];

    for (genvar i = 0; i < CH_PER_PRE; i++) begin : g_ch
      localparam int C = p*CH_PER_PRE + i;
      wire [SEL_W-1:0] sel  = fields[i*SEL_W +: SEL_W];
      wire             div1 = (pbyte == '0) && (int'(sel) >= DIV_W);

      assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> !tick[C]);

      assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed && (!$stable(pbyte) || !$stable(fields)) |=> !tick[C]);

      assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed && tick[C] && !div1 |=> !tick[C]);

      assert_bypass_every_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed && tick[C] && div1 && $stable(pbyte) && $stable(fields) |=> tick[C]);
    end
  end
endmodule

bind pwm_tick_gen pwm_tick_gen_chk #(
  .NCH(NCH), .CH_PER_PRE(CH_PER_PRE), .PRE_W(PRE_W), .SEL_W(SEL_W), .SEL_STRIDE(SEL_STRIDE)
) chk_i (.*);

// File: tb/pwm_tick_gen_tb_top.sv
module pwm_tick_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] prescale_cfg = '0;
  logic [15:0] clksel_cfg = '0;
  logic [3:0]  tick;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  pwm_tick_gen dut_i (.clk(clk), .rst_n(rst_n), .prescale_cfg(prescale_cfg),
                      .clksel_cfg(clksel_cfg), .tick(tick));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Reconfigure (forcing a restart of both pairs) and verify first and second tick index.
  task automatic apply_measure(input string req, input logic [15:0] pre, input logic [15:0] sel,
                               input int d0, input int d1, input int d2, input int d3);
    int d[4];
    int first[4];
    int second[4];
    int dmax;
    d = '{d0, d1, d2, d3};
    dmax = 0;
    for (int i = 0; i < 4; i++) begin
      first[i] = -1; second[i] = -1;
      if (d[i] > dmax) dmax = d[i];
    end
    prescale_cfg = ~pre;
    clksel_cfg   = sel;
    @(negedge clk);
    prescale_cfg = pre;
    @(negedge clk);
    for (int k = 0; k <= 2*dmax; k++) begin
      if (k > 0) @(negedge clk);
      for (int i = 0; i < 4; i++)
        if (tick[i]) begin
          if (first[i] < 0) first[i] = k;
          else if (second[i] < 0) second[i] = k;
        end
    end
    for (int i = 0; i < 4; i++) begin
      check($sformatf("%s ch%0d first tick", req, i), first[i], d[i]);
      check($sformatf("%s ch%0d second tick", req, i), second[i], 2*d[i]);
    end
  endtask

  task automatic t_reset;
    repeat (3) begin
      @(negedge clk);
      check("R1 tick in reset", int'(tick), 0);
    end
    rst_n = 1'b1;
    for (int j = 1; j <= 3; j++) begin
      @(negedge clk);
      check($sformatf("R1 after release j=%0d", j), int'(tick), (j == 2) ? 4'hF : 4'h0);
    end
  endtask

  task automatic t_bypass;
    apply_measure("R6 bypass every cycle", 16'h0000, 16'h4444, 1, 1, 1, 1);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      check("R6 continuous high", int'(tick), 4'hF);
    end
  endtask

  task automatic t_prescale;
    apply_measure("R2 prescale", 16'h0302, 16'h4444, 3, 3, 4, 4);
  endtask

  task automatic t_pairing;
    apply_measure("R3 pair byte map", 16'h0501, 16'h4444, 2, 2, 6, 6);
  endtask

  task automatic t_selectors;
    apply_measure("R5 select codes 0..3", 16'h0101, 16'h3210, 4, 8, 16, 32);
  endtask

  task automatic t_high_codes;
    apply_measure("R7 codes 5..7", 16'h0303, 16'h7654, 4, 4, 4, 4);
  endtask

  task automatic t_reserved;
    apply_measure("R4 field offsets", 16'h0000, 16'h1111, 4, 4, 4, 4);
    clksel_cfg = 16'h9999;
    for (int j = 1; j <= 8; j++) begin
      @(negedge clk);
      check($sformatf("R4 reserved bits ignored j=%0d", j), int'(tick),
            (j == 4 || j == 8) ? 4'hF : 4'h0);
    end
  endtask

  task automatic t_restart;
    apply_measure("R8 setup", 16'h0404, 16'h2222, 40, 40, 40, 40);
    prescale_cfg = 16'h0202;
    for (int j = 1; j <= 25; j++) begin
      @(negedge clk);
      if (j < 25) begin
        if (tick != 4'h0) check($sformatf("R8 early tick j=%0d", j), int'(tick), 0);
      end else begin
        check("R8 first tick at new rate", int'(tick), 4'hF);
      end
    end
  endtask

  task automatic t_isolation;
    apply_measure("R10 setup", 16'h0200, 16'h4444, 1, 1, 3, 3);
    prescale_cfg = 16'h0205;
    for (int j = 1; j <= 7; j++) begin
      @(negedge clk);
      check($sformatf("R10 other pair j=%0d", j), int'(tick[2]), (j % 3 == 0) ? 1 : 0);
      check($sformatf("R8 changed pair j=%0d", j), int'(tick[0]), (j == 7) ? 1 : 0);
    end
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_prescale();
    t_pairing();
    t_selectors();
    t_high_codes();
    t_reserved();
    t_restart();
    t_isolation();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule